// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block models the command and write-state logic of a NOR flash with seven separately erasable blocks and one hardware-locked boot block. A host reaches it through a bus-style port: chip enable, output enable, write strobe, an address and data. Each clock in which the chip enable and the write strobe are both low counts as one bus write. The host issues 8-bit commands that take one or two write cycles. These commands program words, erase blocks, select what reads return, and suspend or resume an erase.

The array is a small behavioural RAM that holds all ones after reset. The array is divided into 64 equal units of `UNIT_WORDS` words each:

- The boot block is 2 units.
- Each of the two parameter blocks is 1 unit.
- The medium main block is 12 units.
- Each of the three large main blocks is 16 units.

`boot_top_i` mirrors this layout so that the boot block sits at the highest addresses instead of the lowest. Real cell timing is replaced by counters. A program stays busy for `PROG_CYCLES` clocks. An erase writes one word per clock, so the block size sets how long it is busy.

Top module: `boot_flash_ctrl`

## Requirements
- R1: After reset, the status register reads 80h, reads return array data, and every array word reads FFh.
- R2: Only a program setup (40h or 10h) followed by a second write changes a word. A single write of a value that is not a command leaves the array unchanged.
- R3: After a program, the word holds the old value ANDed with the written data. Ready returns after `PROG_CYCLES` busy clocks.
- R4: Command 70h selects status reads and FFh selects array reads. After any setup or operation, reads return status until FFh is written.
- R5: Status layout is: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply error. Bits 2:0 always read 0. While a program or erase runs, every read returns status with bit 7 = 0.
- R6: An erase is 20h followed by D0h, where the D0h cycle carries an address inside the target block.
  - Only that block is filled with FFh, at one word per clock.
  - Busy lasts exactly as many clocks as the block has words.
  - With `boot_top_i` = 0 the boot block is at the lowest 2·`UNIT_WORDS` words; with `boot_top_i` = 1 it is at the highest.
- R7: Suspend behaviour during an erase:
  - B0h suspends the erase: ready = 1 and bit 6 = 1.
  - Any other write during the erase is ignored.
  - While suspended, FFh allows array reads.
  - D0h resumes the erase, which then completes.
- R8: A program or erase aimed at the boot block fails if `rp_hv_i` and `wp_i` are both low on the second cycle. On failure the array is unchanged and bit 4 (program) or bit 5 (erase) is set. If either input is high, the operation proceeds.
- R9: An erase setup followed by any value other than D0h sets bits 5 and 4 and erases nothing.
- R10: If `vpp_ok_i` is low on the second cycle, bit 3 is set together with bit 4 (program) or bit 5 (erase), and nothing changes. While bit 3 is set, every later program or erase is refused without touching the array.
- R11: Bits 5 to 3 stay set through any command until 50h is written, and 50h clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low, sampled each clock |
| addr_i | input | AW (9) | Word address |
| data_i | input | DW (8) | Write data or command code in bits 7:0 |
| data_o | output | DW (8) | Read data or status; 0 when not reading |
| boot_top_i | input | 1 | 1 places the boot block at the top of the address space |
| rp_hv_i | input | 1 | Reset pin at super-voltage; unlocks the boot block |
| wp_i | input | 1 | Write-protect pin high; unlocks the boot block |
| vpp_ok_i | input | 1 | Programming supply valid |

## Verification
The hardest state to reach is a suspended erase, because it needs four things to happen in order:

- a correctly gated erase must be running;
- a suspend must arrive while busy;
- an array read must land on a word the erase has not reached yet;
- the resume must be followed by full completion.

The stimulus aims this sequence at a large main block, which stays busy for 128 clocks. It first programs a word 16 addresses above the block base. It then suspends a few clocks after the confirm, so the pointer has not reached that word. Reads taken during the suspend must return the programmed value, and reads taken after resume must return FFh.

// File: rtl/fbc_pkg.sv
`timescale 1ns/1ps
package fbc_pkg;
  localparam int NBLK   = 7;
  localparam int NUNITS = 64;

  localparam logic [7:0] OP_RD_ARRAY = 8'hFF;
  localparam logic [7:0] OP_RD_STAT  = 8'h70;
  localparam logic [7:0] OP_CLR_STAT = 8'h50;
  localparam logic [7:0] OP_PROG     = 8'h40;
  localparam logic [7:0] OP_PROG_ALT = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;

  // error flag positions inside err_q
  localparam int E_VPP   = 0;
  localparam int E_PROG  = 1;
  localparam int E_ERASE = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_PSET, S_ESET, S_PBUSY, S_EBUSY, S_ESUSP
  } seq_state_e;

  // layout in units, boot block first (bottom placement)
  function automatic int blk_start(int b);
    case (b)
      0: return 0;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 16;
      5: return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int blk_units(int b);
    case (b)
      0: return 2;
      1, 2: return 1;
      3: return 12;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/fbc_block_map.sv
`timescale 1ns/1ps
module fbc_block_map import fbc_pkg::*; #(
  parameter int AW = 9,
  parameter int UB = 3
) (
  input  logic [AW-1:0] addr_i,
  input  logic          boot_top_i,
  output logic          boot_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] last_o
);
  localparam int UNIT = 1 << UB;

  int unit_idx;
  logic [NBLK-1:0] hit;

  always_comb begin
    unit_idx = int'(addr_i[AW-1:UB]);
    if (boot_top_i) unit_idx = NUNITS - 1 - unit_idx;
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_hit
    localparam int LO = blk_start(b);
    localparam int HI = LO + blk_units(b) - 1;
    assign hit[b] = (unit_idx >= LO) && (unit_idx <= HI);
  end

  always_comb begin
    int bu;
    int sz;
    bu = 0;
    sz = 1;
    for (int b = 0; b < NBLK; b++) begin
      if (hit[b]) begin
        sz = blk_units(b);
        bu = boot_top_i ? (NUNITS - blk_start(b) - sz) : blk_start(b);
      end
    end
    boot_o = hit[0];
    base_o = AW'(bu * UNIT);
    last_o = AW'((bu + sz) * UNIT - 1);
  end
endmodule

// File: rtl/fbc_array.sv
`timescale 1ns/1ps
module fbc_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/fbc_seq.sv
`timescale 1ns/1ps
module fbc_seq import fbc_pkg::*; #(
  parameter int AW          = 9,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          vpp_ok_i,
  input  logic          unlock_i,
  input  logic          blk_boot_i,
  input  logic [AW-1:0] blk_base_i,
  input  logic [AW-1:0] blk_last_i,
  input  logic [DW-1:0] old_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] rmw_addr_o,
  output logic [7:0]    status_o,
  output logic          busy_o,
  output logic          rd_array_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  seq_state_e    state_q;
  logic          rd_array_q, susp_q;
  logic [2:0]    err_q;
  logic [AW-1:0] addr_q, ptr_q, last_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    cmd;
  logic          suspend_req, clr_req;

  assign cmd         = data_i[7:0];
  assign suspend_req = wr_i && (cmd == OP_SUSPEND) && (state_q == S_EBUSY);
  assign clr_req     = wr_i && (cmd == OP_CLR_STAT) && (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      rd_array_q <= 1'b1;
      susp_q     <= 1'b0;
      err_q      <= '0;
      addr_q     <= '0;
      ptr_q      <= '0;
      last_q     <= '0;
      data_q     <= '0;
      cnt_q      <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (wr_i) begin
          case (cmd)
            OP_RD_ARRAY: rd_array_q <= 1'b1;
            OP_RD_STAT:  rd_array_q <= 1'b0;
            OP_CLR_STAT: err_q <= '0;
            OP_PROG, OP_PROG_ALT: begin
              state_q    <= S_PSET;
              rd_array_q <= 1'b0;
            end
            OP_ERASE: begin
              state_q    <= S_ESET;
              rd_array_q <= 1'b0;
            end
            default: ;
          endcase
        end
        S_PSET: if (wr_i) begin
          state_q <= S_IDLE;
          if (err_q[E_VPP]) begin
            // refused until status is cleared
          end else if (!vpp_ok_i) begin
            err_q[E_VPP]  <= 1'b1;
            err_q[E_PROG] <= 1'b1;
          end else if (blk_boot_i && !unlock_i) begin
            err_q[E_PROG] <= 1'b1;
          end else begin
            state_q <= S_PBUSY;
            addr_q  <= addr_i;
            data_q  <= data_i;
            cnt_q   <= CW'(PROG_CYCLES - 1);
          end
        end
        S_ESET: if (wr_i) begin
          state_q <= S_IDLE;
          if (cmd != OP_CONFIRM) begin
            err_q[E_ERASE] <= 1'b1;
            err_q[E_PROG]  <= 1'b1;
          end else if (err_q[E_VPP]) begin
            // refused until status is cleared
          end else if (!vpp_ok_i) begin
            err_q[E_VPP]   <= 1'b1;
            err_q[E_ERASE] <= 1'b1;
          end else if (blk_boot_i && !unlock_i) begin
            err_q[E_ERASE] <= 1'b1;
          end else begin
            state_q <= S_EBUSY;
            ptr_q   <= blk_base_i;
            last_q  <= blk_last_i;
          end
        end
        S_PBUSY: begin
          if (cnt_q == '0) state_q <= S_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        S_EBUSY: begin
          if (suspend_req) begin
            state_q <= S_ESUSP;
            susp_q  <= 1'b1;
          end else if (ptr_q == last_q) begin
            state_q <= S_IDLE;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        S_ESUSP: if (wr_i) begin
          case (cmd)
            OP_RD_ARRAY: rd_array_q <= 1'b1;
            OP_RD_STAT:  rd_array_q <= 1'b0;
            OP_CONFIRM: begin
              state_q    <= S_EBUSY;
              susp_q     <= 1'b0;
              rd_array_q <= 1'b0;
            end
            default: ;
          endcase
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == S_PBUSY) || (state_q == S_EBUSY);
  assign rd_array_o  = rd_array_q;
  assign status_o    = {~busy_o, susp_q, err_q[E_ERASE], err_q[E_PROG], err_q[E_VPP], 3'b000};
  assign mem_we_o    = ((state_q == S_PBUSY) && (cnt_q == '0)) ||
                       ((state_q == S_EBUSY) && !suspend_req);
  assign mem_addr_o  = (state_q == S_PBUSY) ? addr_q : ptr_q;
  assign mem_wdata_o = (state_q == S_PBUSY) ? (old_i & data_q) : '1;
  assign rmw_addr_o  = addr_q;

  // program busy only follows a program setup cycle
  p_pbusy_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PBUSY && $past(state_q) != S_PBUSY) |-> $past(state_q) == S_PSET);

  p_erase_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EBUSY && $past(state_q) == S_EBUSY) |-> ptr_q == $past(ptr_q) + 1'b1);

  p_susp_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_q) |-> $past(state_q) == S_EBUSY);

  p_boot_unlock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_PBUSY || state_q == S_EBUSY) &&
     ($past(state_q) == S_PSET || $past(state_q) == S_ESET))
    |-> !($past(blk_boot_i) && !$past(unlock_i)));

  p_vpp_refuse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_q[E_VPP]) && ($past(state_q) == S_PSET || $past(state_q) == S_ESET))
    |-> !(state_q == S_PBUSY || state_q == S_EBUSY));

  p_sticky_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_req |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/boot_flash_ctrl.sv
`timescale 1ns/1ps
module boot_flash_ctrl import fbc_pkg::*; #(
  parameter  int UNIT_WORDS  = 8,
  parameter  int DW          = 8,
  parameter  int PROG_CYCLES = 4,
  localparam int UB          = $clog2(UNIT_WORDS),
  localparam int AW          = UB + $clog2(NUNITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  input  logic          boot_top_i,
  input  logic          rp_hv_i,
  input  logic          wp_i,
  input  logic          vpp_ok_i
);
  logic          wr, rd_en, busy, rd_array;
  logic          blk_boot;
  logic [AW-1:0] blk_base, blk_last;
  logic          mem_we;
  logic [AW-1:0] mem_addr, rmw_addr;
  logic [DW-1:0] mem_wdata, arr_rdata, rmw_rdata;
  logic [7:0]    status;

  assign wr    = !ce_ni && !we_ni;
  assign rd_en = !ce_ni && !oe_ni;

  fbc_block_map #(.AW(AW), .UB(UB)) i_map (
    .addr_i     (addr_i),
    .boot_top_i (boot_top_i),
    .boot_o     (blk_boot),
    .base_o     (blk_base),
    .last_o     (blk_last)
  );

  fbc_seq #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .vpp_ok_i    (vpp_ok_i),
    .unlock_i    (rp_hv_i | wp_i),
    .blk_boot_i  (blk_boot),
    .blk_base_i  (blk_base),
    .blk_last_i  (blk_last),
    .old_i       (rmw_rdata),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .rmw_addr_o  (rmw_addr),
    .status_o    (status),
    .busy_o      (busy),
    .rd_array_o  (rd_array)
  );

  fbc_array #(.AW(AW), .DW(DW)) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mem_we),
    .waddr_i   (mem_addr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (addr_i),
    .rdata_a_o (arr_rdata),
    .raddr_b_i (rmw_addr),
    .rdata_b_o (rmw_rdata)
  );

  always_comb begin
    if (!rd_en)                data_o = '0;
    else if (busy || !rd_array) data_o = DW'(status);
    else                       data_o = arr_rdata;
  end

  p_busy_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && busy) |-> (data_o[2:0] == 3'b000 && !data_o[7]));
endmodule

// File: tb/test_boot_flash_ctrl.sv
`timescale 1ns/1ps
module test_boot_flash_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       boot_top = 1'b0, rp_hv = 1'b0, wp = 1'b0, vpp_ok = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_flash_ctrl i_boot_flash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(wdata), .data_o(rdata), .boot_top_i(boot_top),
    .rp_hv_i(rp_hv), .wp_i(wp), .vpp_ok_i(vpp_ok)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] ctl;   // {vpp_ok, wp, rp_hv}
    logic [8:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam logic [1:0] W = 2'd0, RD = 2'd1, PL = 2'd2;
  localparam logic [2:0] N = 3'b100, CWP = 3'b110, CRP = 3'b101, CNV = 3'b000;
  localparam int NV = 76;

  localparam vec_t VEC [NV] = '{
    '{W, N, 9'h000, 8'h70, 8'h00, 4'd1},  // R1 status after reset
    '{RD,N, 9'h000, 8'h00, 8'h80, 4'd1},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd2},  // R2 stray write
    '{W, N, 9'h040, 8'h55, 8'h00, 4'd2},
    '{RD,N, 9'h040, 8'h00, 8'hFF, 4'd2},
    '{W, N, 9'h000, 8'h40, 8'h00, 4'd3},  // R3 program
    '{W, N, 9'h040, 8'hA5, 8'h00, 4'd3},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd3},
    '{RD,N, 9'h040, 8'h00, 8'h80, 4'd4},  // R4 status after op
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd4},
    '{RD,N, 9'h040, 8'h00, 8'hA5, 4'd3},
    '{W, N, 9'h000, 8'h10, 8'h00, 4'd3},  // R3 AND semantics
    '{W, N, 9'h040, 8'h3C, 8'h00, 4'd3},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd3},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd3},
    '{RD,N, 9'h040, 8'h00, 8'h24, 4'd3},
    '{W, N, 9'h000, 8'h40, 8'h00, 4'd8},  // R8 locked boot program
    '{W, N, 9'h003, 8'h00, 8'h00, 4'd8},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd8},
    '{RD,N, 9'h000, 8'h00, 8'h90, 4'd8},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd11}, // R11 sticky through commands
    '{W, N, 9'h000, 8'h70, 8'h00, 4'd11},
    '{RD,N, 9'h000, 8'h00, 8'h90, 4'd11},
    '{W, N, 9'h000, 8'h50, 8'h00, 4'd11},
    '{RD,N, 9'h000, 8'h00, 8'h80, 4'd11},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd8},
    '{RD,N, 9'h003, 8'h00, 8'hFF, 4'd8},
    '{W, CWP,9'h000,8'h40, 8'h00, 4'd8},  // R8 unlock by wp
    '{W, CWP,9'h003,8'h0F, 8'h00, 4'd8},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd8},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd8},
    '{RD,N, 9'h003, 8'h00, 8'h0F, 4'd8},
    '{W, CRP,9'h000,8'h40, 8'h00, 4'd8},  // R8 unlock by rp
    '{W, CRP,9'h004,8'hF0, 8'h00, 4'd8},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd8},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd8},
    '{RD,N, 9'h004, 8'h00, 8'hF0, 4'd8},
    '{W, N, 9'h000, 8'h20, 8'h00, 4'd9},  // R9 bad confirm
    '{W, N, 9'h010, 8'h77, 8'h00, 4'd9},
    '{RD,N, 9'h000, 8'h00, 8'hB0, 4'd9},
    '{W, N, 9'h000, 8'h50, 8'h00, 4'd11},
    '{RD,N, 9'h000, 8'h00, 8'h80, 4'd11},
    '{W, CNV,9'h000,8'h40, 8'h00, 4'd10}, // R10 supply error
    '{W, CNV,9'h050,8'h00, 8'h00, 4'd10},
    '{RD,N, 9'h000, 8'h00, 8'h98, 4'd10},
    '{W, N, 9'h000, 8'h40, 8'h00, 4'd10},
    '{W, N, 9'h050, 8'h00, 8'h00, 4'd10},
    '{RD,N, 9'h000, 8'h00, 8'h98, 4'd10},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd10},
    '{RD,N, 9'h050, 8'h00, 8'hFF, 4'd10},
    '{W, N, 9'h000, 8'h50, 8'h00, 4'd10},
    '{W, N, 9'h000, 8'h40, 8'h00, 4'd10},
    '{W, N, 9'h050, 8'h00, 8'h00, 4'd10},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd10},
    '{RD,N, 9'h000, 8'h00, 8'h80, 4'd10},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd10},
    '{RD,N, 9'h050, 8'h00, 8'h00, 4'd10},
    '{W, N, 9'h000, 8'h40, 8'h00, 4'd6},  // R6 erase one block only
    '{W, N, 9'h014, 8'h00, 8'h00, 4'd6},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd6},
    '{W, N, 9'h000, 8'h40, 8'h00, 4'd6},
    '{W, N, 9'h018, 8'h11, 8'h00, 4'd6},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd6},
    '{W, N, 9'h000, 8'h20, 8'h00, 4'd6},
    '{W, N, 9'h010, 8'hD0, 8'h00, 4'd6},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd6},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd6},
    '{RD,N, 9'h014, 8'h00, 8'hFF, 4'd6},
    '{RD,N, 9'h018, 8'h00, 8'h11, 4'd6},
    '{W, N, 9'h000, 8'h20, 8'h00, 4'd8},  // R8 locked boot erase
    '{W, N, 9'h000, 8'hD0, 8'h00, 4'd8},
    '{PL,N, 9'h000, 8'h00, 8'h00, 4'd8},
    '{RD,N, 9'h000, 8'h00, 8'hA0, 4'd8},
    '{W, N, 9'h000, 8'h50, 8'h00, 4'd8},
    '{W, N, 9'h000, 8'hFF, 8'h00, 4'd8},
    '{RD,N, 9'h003, 8'h00, 8'h0F, 4'd8}
  };

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1 d = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    int n;
    n = 0;
    do begin
      bus_rd(9'h000, s);
      n++;
    end while (!s[7] && n < 2000);
    if (!s[7]) check(5, s, 8'h80, "ready never returned");
  endtask

  // counts clocks with ready low right after an erase confirm
  task automatic count_busy(output int cnt, output logic bad_rsvd);
    cnt = 0;
    bad_rsvd = 1'b0;
    ce_n = 1'b0; oe_n = 1'b0;
    for (int k = 0; k < 1000; k++) begin
      #1;
      if (rdata[7]) break;
      cnt++;
      if (rdata[2:0] != 3'b000) bad_rsvd = 1'b1;
      @(negedge clk);
    end
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    vec_t v;
    int cnt;
    logic bad;

    do_reset();
    // R1 array reads after reset
    bus_rd(9'h000, got); check(1, got, 8'hFF, "array after reset low");
    bus_rd(9'h1FF, got); check(1, got, 8'hFF, "array after reset high");

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      {vpp_ok, wp, rp_hv} = v.ctl;
      case (v.op)
        W:  bus_wr(v.addr, v.data);
        RD: begin
          bus_rd(v.addr, got);
          check(int'(v.req), got, v.exp, $sformatf("vector %0d", i));
        end
        default: wait_ready();
      endcase
    end
    {vpp_ok, wp, rp_hv} = N;

    // R6 erase duration of a parameter block, R5 status while busy
    bus_wr(9'h000, 8'h40); bus_wr(9'h020, 8'h00); wait_ready();
    bus_wr(9'h000, 8'h20); bus_wr(9'h018, 8'hD0);
    count_busy(cnt, bad);
    check(6, 8'(cnt), 8'd8, "param block busy clocks");
    check(5, {7'b0, bad}, 8'h00, "reserved bits during busy");
    bus_wr(9'h000, 8'hFF);
    bus_rd(9'h018, got); check(6, got, 8'hFF, "erased param word");
    bus_rd(9'h020, got); check(6, got, 8'h00, "neighbour block untouched");

    // R7 suspend, read, resume
    bus_wr(9'h000, 8'h40); bus_wr(9'h090, 8'h00); wait_ready();
    bus_wr(9'h000, 8'h20); bus_wr(9'h080, 8'hD0);
    bus_wr(9'h000, 8'hFF);
    bus_rd(9'h090, got); check(7, {7'b0, got[7]}, 8'h00, "non-suspend write ignored while erasing");
    bus_wr(9'h000, 8'hB0);
    wait_ready();
    bus_rd(9'h000, got); check(7, got, 8'hC0, "suspended status");
    bus_wr(9'h000, 8'hFF);
    bus_rd(9'h090, got); check(7, got, 8'h00, "array read in suspend");
    bus_wr(9'h000, 8'hD0);
    bus_rd(9'h000, got); check(7, {7'b0, got[7]}, 8'h00, "busy after resume");
    wait_ready();
    bus_rd(9'h000, got); check(7, got, 8'h80, "status after resumed erase");
    bus_wr(9'h000, 8'hFF);
    bus_rd(9'h090, got); check(7, got, 8'hFF, "word erased after resume");

    // R6 and R8 with the boot block at the top
    boot_top = 1'b1;
    do_reset();
    bus_wr(9'h000, 8'h40); bus_wr(9'h1F8, 8'h00); wait_ready();
    bus_rd(9'h000, got); check(8, got, 8'h90, "top boot locked");
    bus_wr(9'h000, 8'h50);
    bus_wr(9'h000, 8'h40); bus_wr(9'h003, 8'h00); wait_ready();
    bus_wr(9'h000, 8'hFF);
    bus_rd(9'h003, got); check(6, got, 8'h00, "low word is main block when top");
    wp = 1'b1;
    bus_wr(9'h000, 8'h40); bus_wr(9'h1F8, 8'h00); wait_ready();
    bus_wr(9'h000, 8'h20); bus_wr(9'h1F0, 8'hD0);
    count_busy(cnt, bad);
    wp = 1'b0;
    check(6, 8'(cnt), 8'd16, "top boot erase busy clocks");
    bus_wr(9'h000, 8'hFF);
    bus_rd(9'h1F8, got); check(8, got, 8'hFF, "top boot erased when unlocked");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule